// File: doc/BRIEF.md
# Transition-Based Loss-of-Signal Monitor

This block watches a sampled bit-serial data stream and declares loss of signal when transitions stop. It runs on a system clock and advances one bit time on each cycle where the bit-rate enable is high. While loss of signal is declared, the reference-select output tells an external clock-recovery loop to lock to the local reference instead of the incoming data. The loop itself is outside this block.

The quiet-time limit comes from a coarse, free-running prescaler. The declaration delay therefore depends on where in the prescaler period the last transition fell. A force input can impose loss of signal at any time. While it is high, the data is squelched to zero, so no transitions reach the detector. Loss of signal clears only when the force input is low and the returning data passes a density and run-length test. One-cycle pulses mark each entry into and each exit from loss of signal.

Top module: `sig_loss_mon`

## Requirements
- R1: While the link is up and the force input is low, a free-running prescaler cycles through 128 bit times. The first prescaler wrap after the last data transition arms a 96-bit-time timer, and loss of signal is declared when that timer expires with no transition seen. The declaration delay measured from the last transition therefore falls between 96 and 224 bit times.
- R2: `ref_sel_o` equals `los_o` at all times. A value of 1 selects the local reference and 0 selects the data.
- R3: While `force_los_i` is 1, `data_o` is 0. Otherwise `data_o` equals `data_i`.
- R4: When `force_los_i` is 1 on an enabled bit time, `los_o` is 1 from the next clock edge. This is well within 128 bit times.
- R5: While loss of signal is declared and `force_los_i` is 0, the monitor counts windows of 256 consecutive bit times. A window that holds at least 32 transitions clears `los_o`. A window with fewer than 32 transitions starts a new window.
- R6: A run of more than 64 identical squelched bits during recovery discards the current window, and a new window starts after that bit.
- R7: During and after reset, `los_o` and `ref_sel_o` are 1 and both pulse outputs are 0.
- R8: `los_set_o` is high for exactly the one cycle in which `los_o` goes from 0 to 1. `los_clr_o` is high for exactly the one cycle in which `los_o` goes from 1 to 0.
- R9: When `bit_en_i` is 0, no state advances and `los_o` holds its value.
- R10: Transitions are taken from the squelched data. While `force_los_i` is 1, toggling `data_i` neither recovers the link nor counts toward a recovery window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-bit-time enable |
| data_i | input | 1 | Sampled serial data |
| force_los_i | input | 1 | Forces loss of signal and squelches the data |
| data_o | output | 1 | Squelched serial data |
| los_o | output | 1 | Loss of signal declared |
| ref_sel_o | output | 1 | 1 selects the local reference for the clock-recovery loop |
| los_set_o | output | 1 | One-cycle pulse on each loss-of-signal entry |
| los_clr_o | output | 1 | One-cycle pulse on each loss-of-signal exit |

## Verification
The assertions assume that `force_los_i` and `data_i` change only once per system clock, and that reset is held for at least one clock edge so that the past-value checks start from the reset state.

The bench drives every input at the falling edge and keeps all inputs low through reset. Gaps in `bit_en_i` are mixed into the stimulus so that the freeze rule is exercised. Because the bench keeps the force input low through reset, the rule that a clear needs the force input released is covered from the first edge onward.

// File: rtl/sig_loss_pkg.sv
`timescale 1ns/1ps
package sig_loss_pkg;
  typedef enum logic {
    LINK_UP   = 1'b0,
    LINK_LOST = 1'b1
  } link_e;

  localparam int unsigned DEF_PRESCALE  = 128;
  localparam int unsigned DEF_ARM_LEN   = 96;
  localparam int unsigned DEF_WIN_LEN   = 256;
  localparam int unsigned DEF_MAX_RUN   = 64;
  localparam int unsigned DEF_MIN_TRANS = 32;
endpackage

// File: rtl/sig_loss_prescaler.sv
`timescale 1ns/1ps
module sig_loss_prescaler #(
  parameter int unsigned PRESCALE = sig_loss_pkg::DEF_PRESCALE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  output logic wrap_o
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PW-1:0] cnt_q;
  logic          at_top;

  assign at_top = (cnt_q == PW'(PRESCALE - 1));
  assign wrap_o = bit_en_i & at_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (bit_en_i) begin
      cnt_q <= at_top ? '0 : cnt_q + PW'(1);
    end
  end
endmodule

// File: rtl/sig_loss_edge.sv
`timescale 1ns/1ps
module sig_loss_edge #(
  parameter int unsigned MAX_RUN = sig_loss_pkg::DEF_MAX_RUN
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic data_i,
  input  logic force_i,
  output logic data_o,
  output logic trans_o,
  output logic run_long_o
);
  localparam int unsigned RW = $clog2(MAX_RUN + 2);

  logic          sq;
  logic          prev_q;
  logic          diff;
  logic [RW-1:0] run_q;
  logic [RW-1:0] run_nx;

  // squelch: forced condition blanks the line
  assign sq     = data_i & ~force_i;
  assign data_o = sq;
  assign diff   = sq ^ prev_q;

  always_comb begin
    if (diff) begin
      run_nx = RW'(1);
    end else if (run_q == RW'(MAX_RUN + 1)) begin
      run_nx = run_q;
    end else begin
      run_nx = run_q + RW'(1);
    end
  end

  assign trans_o    = bit_en_i & diff;
  assign run_long_o = bit_en_i & (run_nx > RW'(MAX_RUN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      run_q  <= '0;
    end else if (bit_en_i) begin
      prev_q <= sq;
      run_q  <= run_nx;
    end
  end
endmodule

// File: rtl/sig_loss_qual.sv
`timescale 1ns/1ps
module sig_loss_qual #(
  parameter int unsigned WIN_LEN   = sig_loss_pkg::DEF_WIN_LEN,
  parameter int unsigned MIN_TRANS = sig_loss_pkg::DEF_MIN_TRANS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic active_i,
  input  logic trans_i,
  input  logic run_long_i,
  output logic good_o
);
  localparam int unsigned WW = $clog2(WIN_LEN + 1);

  logic [WW-1:0] wcnt_q, tcnt_q;
  logic [WW-1:0] w_nx, t_nx;
  logic          win_end;

  assign w_nx    = wcnt_q + WW'(1);
  assign t_nx    = tcnt_q + WW'(trans_i);
  assign win_end = (w_nx == WW'(WIN_LEN));
  assign good_o  = bit_en_i & active_i & ~run_long_i & win_end &
                   (t_nx >= WW'(MIN_TRANS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      tcnt_q <= '0;
    end else if (bit_en_i) begin
      if (!active_i || run_long_i || win_end) begin
        // idle, run too long, or window finished: start over
        wcnt_q <= '0;
        tcnt_q <= '0;
      end else begin
        wcnt_q <= w_nx;
        tcnt_q <= t_nx;
      end
    end
  end
endmodule

// File: rtl/sig_loss_mon.sv
`timescale 1ns/1ps
module sig_loss_mon #(
  parameter int unsigned PRESCALE  = sig_loss_pkg::DEF_PRESCALE,
  parameter int unsigned ARM_LEN   = sig_loss_pkg::DEF_ARM_LEN,
  parameter int unsigned WIN_LEN   = sig_loss_pkg::DEF_WIN_LEN,
  parameter int unsigned MAX_RUN   = sig_loss_pkg::DEF_MAX_RUN,
  parameter int unsigned MIN_TRANS = sig_loss_pkg::DEF_MIN_TRANS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic data_i,
  input  logic force_los_i,
  output logic data_o,
  output logic los_o,
  output logic ref_sel_o,
  output logic los_set_o,
  output logic los_clr_o
);
  import sig_loss_pkg::*;

  localparam int unsigned TW = $clog2(ARM_LEN);

  logic          wrap, trans, run_long, good, qual_active;
  link_e         link_q, link_d;
  logic          arm_q, arm_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          set_q, clr_q;

  sig_loss_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_en_i (bit_en_i),
    .wrap_o   (wrap)
  );

  sig_loss_edge #(.MAX_RUN(MAX_RUN)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_en_i   (bit_en_i),
    .data_i     (data_i),
    .force_i    (force_los_i),
    .data_o     (data_o),
    .trans_o    (trans),
    .run_long_o (run_long)
  );

  assign qual_active = (link_q == LINK_LOST) & ~force_los_i;

  sig_loss_qual #(.WIN_LEN(WIN_LEN), .MIN_TRANS(MIN_TRANS)) u_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_en_i   (bit_en_i),
    .active_i   (qual_active),
    .trans_i    (trans),
    .run_long_i (run_long),
    .good_o     (good)
  );

  always_comb begin
    link_d = link_q;
    arm_d  = arm_q;
    tmr_d  = tmr_q;
    if (bit_en_i) begin
      if (link_q == LINK_LOST) begin
        arm_d = 1'b0;
        tmr_d = '0;
        if (good) link_d = LINK_UP;
      end else if (force_los_i) begin
        link_d = LINK_LOST;
        arm_d  = 1'b0;
        tmr_d  = '0;
      end else if (trans) begin
        arm_d = 1'b0;
        tmr_d = '0;
      end else if (arm_q) begin
        if (tmr_q == TW'(ARM_LEN - 1)) begin
          link_d = LINK_LOST;
          arm_d  = 1'b0;
          tmr_d  = '0;
        end else begin
          tmr_d = tmr_q + TW'(1);
        end
      end else if (wrap) begin
        // first wrap after last transition arms the quiet timer
        arm_d = 1'b1;
        tmr_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_q <= LINK_LOST;
      arm_q  <= 1'b0;
      tmr_q  <= '0;
      set_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      link_q <= link_d;
      arm_q  <= arm_d;
      tmr_q  <= tmr_d;
      set_q  <= (link_d == LINK_LOST) && (link_q == LINK_UP);
      clr_q  <= (link_d == LINK_UP) && (link_q == LINK_LOST);
    end
  end

  assign los_o     = (link_q == LINK_LOST);
  assign ref_sel_o = (link_q == LINK_LOST);
  assign los_set_o = set_q;
  assign los_clr_o = clr_q;
endmodule

// File: rtl/sig_loss_chk.sv
`timescale 1ns/1ps
module sig_loss_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic data_i,
  input logic force_los_i,
  input logic data_o,
  input logic los_o,
  input logic ref_sel_o,
  input logic los_set_o,
  input logic los_clr_o
);
  p_ref_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_sel_o == los_o);

  p_squelch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_los_i |-> (data_o == 1'b0));

  p_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !force_los_i |-> (data_o == data_i));

  p_force_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && force_los_i) |=> los_o);

  p_clr_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_clr_o |-> !$past(force_los_i));

  p_set_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_set_o |-> (los_o && !$past(los_o)));

  p_clr_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    los_clr_o |-> (!los_o && $past(los_o)));

  p_rise_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(los_o) |-> los_set_o);

  p_freeze_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(los_o));
endmodule

bind sig_loss_mon sig_loss_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bit_en_i    (bit_en_i),
  .data_i      (data_i),
  .force_los_i (force_los_i),
  .data_o      (data_o),
  .los_o       (los_o),
  .ref_sel_o   (ref_sel_o),
  .los_set_o   (los_set_o),
  .los_clr_o   (los_clr_o)
);

// File: tb/sim_sig_loss_mon.sv
`timescale 1ns/1ps
module sim_sig_loss_mon;
  logic clk = 1'b0;
  logic rst_ni;
  logic bit_en, din, frc;
  logic data_o, los_o, ref_sel_o, los_set_o, los_clr_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit bd = 1'b0;

  // bench model state
  int m_presc, m_tmr, m_run, m_wcnt, m_tcnt;
  bit m_prev, m_arm, m_los, m_set, m_clr;
  bit cur_d, cur_f;

  always #5 clk = ~clk;

  sig_loss_mon u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .bit_en_i    (bit_en),
    .data_i      (din),
    .force_los_i (frc),
    .data_o      (data_o),
    .los_o       (los_o),
    .ref_sel_o   (ref_sel_o),
    .los_set_o   (los_set_o),
    .los_clr_o   (los_clr_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_data(input bit d, input bit f);
    return d & ~f;
  endfunction

  function automatic bit in_window(input int n);
    return (n >= 96) && (n <= 224);
  endfunction

  task automatic model_reset();
    m_presc = 0; m_tmr = 0; m_run = 0; m_wcnt = 0; m_tcnt = 0;
    m_prev = 0; m_arm = 0; m_los = 1; m_set = 0; m_clr = 0;
  endtask

  task automatic model_step(input bit en, input bit d, input bit f);
    bit sq, tr, wrap, was;
    m_set = 0; m_clr = 0;
    if (!en) return;
    sq = exp_data(d, f);
    tr = (sq != m_prev);
    m_prev = sq;
    wrap = (m_presc == 127);
    m_presc = (m_presc + 1) % 128;
    if (tr) m_run = 1; else if (m_run < 65) m_run++;
    was = m_los;
    if (!was) begin
      if (f) begin m_los = 1; m_arm = 0; m_tmr = 0; end
      else if (tr) begin m_arm = 0; m_tmr = 0; end
      else if (m_arm) begin
        if (m_tmr == 95) begin m_los = 1; m_arm = 0; m_tmr = 0; end
        else m_tmr++;
      end else if (wrap) begin m_arm = 1; m_tmr = 0; end
      m_wcnt = 0; m_tcnt = 0;
    end else begin
      m_arm = 0; m_tmr = 0;
      if (f || m_run > 64) begin m_wcnt = 0; m_tcnt = 0; end
      else begin
        m_wcnt++;
        m_tcnt += int'(tr);
        if (m_wcnt == 256) begin
          if (m_tcnt >= 32) m_los = 0;
          m_wcnt = 0; m_tcnt = 0;
        end
      end
    end
    m_set = !was && m_los;
    m_clr = was && !m_los;
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic drive(input bit en, input bit d, input bit f);
    bit_en = en; din = d; frc = f; cur_d = d; cur_f = f;
    @(posedge clk);
    model_step(en, d, f);
    @(negedge clk);
    check(los_o == m_los, "R1 los", int'(los_o), int'(m_los));
    check(ref_sel_o == m_los, "R2 ref_sel", int'(ref_sel_o), int'(m_los));
    check(data_o == exp_data(cur_d, cur_f), "R3 data", int'(data_o), int'(exp_data(cur_d, cur_f)));
    check(los_set_o == m_set, "R8 set pulse", int'(los_set_o), int'(m_set));
    check(los_clr_o == m_clr, "R8 clr pulse", int'(los_clr_o), int'(m_clr));
  endtask

  task automatic toggle_bits(input int n);
    for (int i = 0; i < n; i++) begin
      bd = ~bd;
      drive(1'b1, bd, 1'b0);
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd20240611));
    rst_ni = 1'b0; bit_en = 1'b1; din = 1'b0; frc = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7 reset state
    check(los_o == 1'b1, "R7 los", int'(los_o), 1);
    check(ref_sel_o == 1'b1, "R7 ref_sel", int'(ref_sel_o), 1);
    check(los_set_o == 1'b0 && los_clr_o == 1'b0, "R7 pulses", int'(los_set_o | los_clr_o), 0);
    rst_ni = 1'b1;

    // R5 dense data recovers
    toggle_bits(300);
    check(los_o == 1'b0, "R5 dense recovery", int'(los_o), 0);

    // R1 quiet declaration at several prescaler phases
    for (int k = 0; k < 6; k++) begin
      toggle_bits(1 + (k * 37) % 128);
      n = 0;
      while (!los_o && n < 300) begin
        drive(1'b1, bd, 1'b0);
        n++;
      end
      check(in_window(n), "R1 quiet window", n, 160);
      toggle_bits(300);
    end

    // R6 long run discards window
    n = 0;
    while (!los_o && n < 300) begin drive(1'b1, bd, 1'b0); n++; end
    toggle_bits(100);
    for (int i = 0; i < 70; i++) drive(1'b1, bd, 1'b0);
    toggle_bits(180);
    check(los_o == 1'b1, "R6 run restarts window", int'(los_o), 1);
    toggle_bits(100);
    check(los_o == 1'b0, "R6 later recovery", int'(los_o), 0);

    // R5 sparse data does not recover, denser does
    n = 0;
    while (!los_o && n < 300) begin drive(1'b1, bd, 1'b0); n++; end
    for (int i = 0; i < 800; i++) begin
      if (i % 10 == 0) bd = ~bd;
      drive(1'b1, bd, 1'b0);
    end
    check(los_o == 1'b1, "R5 sparse stays lost", int'(los_o), 1);
    for (int i = 0; i < 600; i++) begin
      if (i % 6 == 0) bd = ~bd;
      drive(1'b1, bd, 1'b0);
    end
    check(los_o == 1'b0, "R5 threshold recovery", int'(los_o), 0);

    // R4 / R3 / R10 forced condition
    drive(1'b1, 1'b1, 1'b1);
    check(los_o == 1'b1, "R4 forced declare", int'(los_o), 1);
    check(data_o == 1'b0, "R3 squelch", int'(data_o), 0);
    for (int i = 0; i < 400; i++) drive(1'b1, i[0], 1'b1);
    check(los_o == 1'b1, "R10 forced blocks recovery", int'(los_o), 1);
    toggle_bits(300);
    check(los_o == 1'b0, "R5 after release", int'(los_o), 0);

    // R9 enable low freezes everything
    for (int i = 0; i < 400; i++) drive(1'b0, bd, 1'b0);
    check(los_o == 1'b0, "R9 frozen", int'(los_o), 0);
    n = 0;
    while (!los_o && n < 300) begin drive(1'b1, bd, 1'b0); n++; end
    check(in_window(n), "R9 resumes quiet count", n, 160);

    // constrained random mix
    for (int blk = 0; blk < 40; blk++) begin
      int tp, len;
      bit fon;
      tp = 1 + $urandom_range(0, 40);
      fon = ($urandom_range(0, 7) == 0);
      len = 50 + $urandom_range(0, 300);
      for (int i = 0; i < len; i++) begin
        if ($urandom_range(0, tp) == 0) bd = ~bd;
        drive($urandom_range(0, 9) != 0, bd, fon && (i < len / 2));
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule